// File: doc/BRIEF.md
# Circular-Buffer FIFO with Direction-Tracked Flags

This block is a single-clock first-in/first-out queue. Storage is a dual-port RAM used as a ring, indexed by two independent address counters. The write counter advances on each accepted write and the read counter advances on each accepted read. One equality comparator watches the two counters. Matching addresses can mean an empty ring or a full one. A one-bit state machine tells the two cases apart by recording which side made the most recent unbalanced move.

A producer drives `push` with `push_data`, and a consumer drives `pop`. The popped word appears on `pop_data` in the cycle after the pop is accepted, as it would from a registered RAM read port. It then holds until the next accepted pop. A push into a full queue is dropped, and so is a pop from an empty one.

Top module: `ring_fifo`

## Requirements
- R1: After reset `is_empty` is 1, `is_full` is 0 and `pop_data` is 0.
- R2: Words leave in the order they were accepted. The word for an accepted pop is on `pop_data` in the cycle after the edge that accepted it.
- R3: `is_full` is 1 exactly when the queue holds 2**ADDR_W words. It can only become 1 through an accepted push.
- R4: `is_empty` is 1 exactly when the queue holds no words.
- R5: A push while `is_full` is 1 is dropped. The stored contents and the flags are unchanged, and the dropped word is never popped.
- R6: A pop while `is_empty` is 1 is dropped. `pop_data` keeps its value and `is_empty` stays 1.
- R7: When a push and a pop are both accepted in the same cycle, the occupancy and both flags are unchanged.
- R8: A push and a pop in the same cycle while full accept only the pop, so the queue leaves full. While empty they accept only the push, so the queue leaves empty.
- R9: `pop_data` changes only after an accepted pop.
- R10: Both address counters wrap modulo 2**ADDR_W. Ordering and flags stay correct over many passes around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | DATA_W | Word read, registered |
| is_full | output | 1 | Queue holds 2**ADDR_W words |
| is_empty | output | 1 | Queue holds no words |

## Verification
The bench builds the block with ADDR_W=3 and DATA_W=8. With an eight-deep ring, the full flag, writes dropped at full, and simultaneous traffic at both extremes can be reached within a few cycles. A long random stretch then drives both counters through dozens of wraps. This exposes any confusion between the filling and emptying states that only appears after the addresses meet again from the opposite direction.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;
  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } dir_e;

  // Direction update: only an unbalanced accepted move changes it.
  function automatic dir_e dir_next(input dir_e cur, input logic wr_acc, input logic rd_acc);
    if (wr_acc && !rd_acc) return DIR_FILL;
    if (rd_acc && !wr_acc) return DIR_DRAIN;
    return cur;
  endfunction
endpackage

// File: rtl/fifo_addr_ctr.sv
module fifo_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (step) addr <= addr_inc(addr);
  end
endmodule

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/fifo_dir_fsm.sv
module fifo_dir_fsm
  import ring_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_acc,
  input  logic rd_acc,
  input  logic addr_eq,
  output logic full,
  output logic empty,
  output logic filling
);
  dir_e dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= DIR_DRAIN;
    else        dir_q <= dir_next(dir_q, wr_acc, rd_acc);
  end

  assign filling = (dir_q == DIR_FILL);
  assign full    = filling && addr_eq;
  assign empty   = !filling && addr_eq;
endmodule

// File: rtl/ring_fifo.sv
module ring_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              is_full,
  output logic              is_empty
);
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic wr_take, rd_take, ptr_match, fill_state;

  // Named events for the checker.
  assign wr_take   = push && !is_full;
  assign rd_take   = pop && !is_empty;
  assign ptr_match = (wr_addr == rd_addr);

  fifo_addr_ctr #(.ADDR_W(ADDR_W)) u_wr_ctr (
    .clk(clk), .rst_n(rst_n), .step(wr_take), .addr(wr_addr)
  );

  fifo_addr_ctr #(.ADDR_W(ADDR_W)) u_rd_ctr (
    .clk(clk), .rst_n(rst_n), .step(rd_take), .addr(rd_addr)
  );

  fifo_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_take), .waddr(wr_addr), .wdata(push_data),
    .re(rd_take), .raddr(rd_addr), .rdata(pop_data)
  );

  fifo_dir_fsm u_dir (
    .clk(clk), .rst_n(rst_n),
    .wr_acc(wr_take), .rd_acc(rd_take), .addr_eq(ptr_match),
    .full(is_full), .empty(is_empty), .filling(fill_state)
  );
endmodule

// File: rtl/ring_fifo_chk.sv
module ring_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic              pop,
  input logic              wr_take,
  input logic              rd_take,
  input logic              fill_state,
  input logic [DATA_W-1:0] pop_data,
  input logic              is_full,
  input logic              is_empty
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_full && is_empty)); // R4

  AST_FULL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_full) |-> $past(wr_take) && fill_state); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_full && push && !pop |=> is_full); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty && pop && !push |=> is_empty && $stable(pop_data)); // R6

  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take && rd_take |=> !is_full && !is_empty); // R7

  AST_FULL_POP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    is_full && pop |=> !is_full); // R8

  AST_EMPTY_PUSH_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty && push |=> !is_empty); // R8

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> $stable(pop_data)); // R9
endmodule

bind ring_fifo ring_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
  .wr_take(wr_take), .rd_take(rd_take), .fill_state(fill_state),
  .pop_data(pop_data), .is_full(is_full), .is_empty(is_empty)
);

// File: tb/tb_ring_fifo.sv
module tb_ring_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic [DATA_W-1:0] pop_data;
  logic is_full, is_empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] exp_data = '0;

  always #4 clk = ~clk;

  ring_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .is_full(is_full), .is_empty(is_empty)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "pop_data", int'(pop_data), int'(exp_data));
    check(tag, "is_full", int'(is_full), int'(q.size() == DEPTH));
    check(tag, "is_empty", int'(is_empty), int'(q.size() == 0));
  endtask

  // One clock: drive at falling edge, update model at rising edge, sample after.
  task automatic step(input bit w, input bit r, input logic [DATA_W-1:0] d, input string tag);
    bit wacc, racc;
    @(negedge clk);
    push = w; pop = r; push_data = d;
    wacc = w && (q.size() < DEPTH);
    racc = r && (q.size() > 0);
    @(posedge clk);
    if (racc) exp_data = q.pop_front();
    if (wacc) q.push_back(d);
    #2;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R4: short burst in, then out
    for (int i = 0; i < 3; i++) step(1, 0, 8'h10 + 8'(i), "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 8'h00, "R2");
    step(0, 0, 8'h00, "R4");

    // R6: pops on empty are dropped, data holds
    step(0, 1, 8'h00, "R6");
    step(0, 1, 8'h00, "R6");
    step(0, 0, 8'h00, "R9");

    // R3: fill to depth
    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'h40 + 8'(i), "R3");
    // R5: pushes on full dropped
    step(1, 0, 8'hEE, "R5");
    step(1, 0, 8'hEF, "R5");
    // R8: push+pop at full takes only the pop
    step(1, 1, 8'hDD, "R8");
    step(0, 0, 8'h00, "R9");
    // drain and confirm order; dropped words never show
    for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00, "R5");
    step(0, 0, 8'h00, "R4");

    // R8: push+pop at empty takes only the push
    step(1, 1, 8'h77, "R8");
    // R7: balanced traffic in the middle
    step(1, 0, 8'h78, "R7");
    for (int i = 0; i < 6; i++) step(1, 1, 8'h80 + 8'(i), "R7");
    step(0, 1, 8'h00, "R2");
    step(0, 1, 8'h00, "R2");
    step(0, 1, 8'h00, "R2");

    // R10: long random traffic wrapping the counters
    for (int i = 0; i < 600; i++) begin
      int v = $urandom;
      step(v[0] | v[3], v[1] | v[4], v[15:8], "R10");
    end
    while (q.size() > 0) step(0, 1, 8'h00, "R10");
    step(0, 1, 8'h00, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule